// File: doc/BRIEF.md
# Memory-Mapped GPIO Output and Direction Bank

This block is a register bank for a wide general-purpose I/O port of 192 pins, grouped 32 pins to a 32-bit word. A simple register bus carries an address, a write strobe with write data, and a read strobe. Read data comes back one cycle after the read strobe. Each pin has an output latch, a direction bit and a synchronized copy of its pad input. The block drives the output latch and the direction bit straight to the pad as `pad_out` and `pad_oe`.

Each register type takes a run of consecutive words, with words 4 bytes apart. Pin n sits in word n/32 of a run at bit n%32. The output latch is never written directly. Software writes ones to a set run to raise pins and ones to a clear run to lower them, so it never needs a read-modify-write sequence to change a single pin. The direction run is an ordinary read/write register. The level run reports the synchronized pad inputs. One configuration word at offset zero is plain read/write storage.

Top module: `gpio_bank`

## Requirements
- R1: After reset every output latch is 0, every direction bit is 0 (input), and the direction words read back as 0.
- R2: A write to byte address 0x034 + 4k makes every pin whose data bit is 1 in word k drive `pad_out` high from the next cycle. Pins whose data bit is 0 keep their latch value.
- R3: A write to byte address 0x04c + 4k makes every pin whose data bit is 1 in word k drive `pad_out` low from the next cycle. Pins whose data bit is 0 keep their latch value.
- R4: The direction word k at byte address 0x01c + 4k is read/write. A bit value of 1 makes `pad_oe` of that pin high (output) and a value of 0 makes it low (input).
- R5: The level word k at byte address 0x004 + 4k returns `pad_in` through a two-flop synchronizer. A pad change made before clock edge e is first returned by a read that is captured at edge e+2. Writes to level words have no effect.
- R6: The set and clear words read back as zero.
- R7: `bus_rdata` holds the selected word in the cycle after a cycle with `bus_rd_en` high, and is zero after a cycle with `bus_rd_en` low.
- R8: An address of 0x064 or above, or an address whose two low bits are not 00, reads as zero and its writes change no latch, direction bit or configuration word.
- R9: The word at byte address 0x000 is read/write storage that resets to 0 and does not affect any pad output.
- R10: Pin n is controlled by bit n%32 of word n/32 in every run, across all six words (pins 0 to 191).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_wr_en | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd_en | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, registered |
| pad_in | input | 192 | Pad input levels |
| pad_out | output | 192 | Output latch per pin |
| pad_oe | output | 192 | Output enable per pin (direction) |

## Verification
The assertions check on every cycle that a set write raises each addressed bit and a clear write lowers it. They also check that a word with no write keeps its latch and direction, and that reads of write-only or unmapped addresses return zero. Several behaviours need the bench scenarios instead. These are the exact two-cycle synchronizer latency, the mapping of pins at the word edges (pins 31, 32 and 191), the fact that writes to level, unaligned and out-of-range addresses change nothing, and the configuration word's read-back.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    typedef enum logic [2:0] {
        RK_NONE  = 3'd0,
        RK_CFG   = 3'd1,
        RK_LEVEL = 3'd2,
        RK_DIR   = 3'd3,
        RK_SET   = 3'd4,
        RK_CLR   = 3'd5
    } reg_kind_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH = 192
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stab;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = async_in;
        st_d.stab = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.stab;

endmodule

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
    import gpio_bank_pkg::*;
#(
    parameter int                ADDR_W    = 12,
    parameter int                NUM_WORDS = 6,
    parameter int                WIDX_W    = 3,
    parameter logic [ADDR_W-1:0] CFG_BASE  = 12'h000,
    parameter logic [ADDR_W-1:0] LVL_BASE  = 12'h004,
    parameter logic [ADDR_W-1:0] DIR_BASE  = 12'h01c,
    parameter logic [ADDR_W-1:0] SET_BASE  = 12'h034,
    parameter logic [ADDR_W-1:0] CLR_BASE  = 12'h04c
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output logic [WIDX_W-1:0] word
);

    localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(NUM_WORDS * 4);

    function automatic logic in_run(input logic [ADDR_W-1:0] a,
                                    input logic [ADDR_W-1:0] base);
        return (a >= base) && (a < base + SPAN);
    endfunction

    logic [ADDR_W-1:0] rel;

    always_comb begin
        kind = RK_NONE;
        rel  = '0;
        if (addr[1:0] == 2'b00) begin
            if (addr == CFG_BASE) begin
                kind = RK_CFG;
            end else if (in_run(addr, LVL_BASE)) begin
                kind = RK_LEVEL;
                rel  = addr - LVL_BASE;
            end else if (in_run(addr, DIR_BASE)) begin
                kind = RK_DIR;
                rel  = addr - DIR_BASE;
            end else if (in_run(addr, SET_BASE)) begin
                kind = RK_SET;
                rel  = addr - SET_BASE;
            end else if (in_run(addr, CLR_BASE)) begin
                kind = RK_CLR;
                rel  = addr - CLR_BASE;
            end
        end
        word = WIDX_W'(rel >> 2);
    end

endmodule

// File: rtl/gpio_pin_word.sv
module gpio_pin_word #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_dir,
    input  logic              wr_set,
    input  logic              wr_clr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] out_q,
    output logic [WORD_W-1:0] dir_q
);

    typedef struct packed {
        logic [WORD_W-1:0] outl;
        logic [WORD_W-1:0] dir;
    } word_st_t;

    word_st_t st_d, st_q;
    logic [WORD_W-1:0] set_m, clr_m;

    always_comb begin
        st_d  = st_q;
        set_m = wr_set ? wdata : '0;
        clr_m = wr_clr ? wdata : '0;
        // set wins over clear on the same bit
        st_d.outl = (st_q.outl & ~clr_m) | set_m;
        if (wr_dir) st_d.dir = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_q = st_q.outl;
    assign dir_q = st_q.dir;

    // R2: set write raises every addressed bit
    p_set_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((out_q & $past(wdata)) == $past(wdata)));

    // R3: clear write lowers every addressed bit
    p_clr_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr && !wr_set) |=> ((out_q & $past(wdata)) == '0));

    // R4: a word with no write keeps latch and direction
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_set && !wr_clr && !wr_dir) |=> ($stable(out_q) && $stable(dir_q)));

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 192,
    parameter int WORD_W   = 32,
    parameter int ADDR_W   = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr_en,
    input  logic [WORD_W-1:0]   bus_wdata,
    input  logic                bus_rd_en,
    output logic [WORD_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe
);

    localparam int NUM_WORDS = (NUM_PINS + WORD_W - 1) / WORD_W;
    localparam int WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
    localparam int PAD_W     = NUM_WORDS * WORD_W;

    typedef struct packed {
        logic [WORD_W-1:0] cfg;
        logic [WORD_W-1:0] rdata;
    } top_st_t;

    top_st_t st_d, st_q;

    reg_kind_e         dec_kind;
    logic [WIDX_W-1:0] dec_word;
    logic [PAD_W-1:0]  pad_in_w, lvl_all, out_all, dir_all;
    logic [WORD_W-1:0] lvl_word [NUM_WORDS];
    logic [WORD_W-1:0] dir_word [NUM_WORDS];

    generate
        if (PAD_W > NUM_PINS) begin : g_pad_ext
            assign pad_in_w = {{(PAD_W-NUM_PINS){1'b0}}, pad_in};
        end else begin : g_pad_exact
            assign pad_in_w = pad_in;
        end
    endgenerate

    gpio_sync #(.WIDTH(PAD_W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in_w),
        .sync_out (lvl_all)
    );

    gpio_addr_dec #(
        .ADDR_W    (ADDR_W),
        .NUM_WORDS (NUM_WORDS),
        .WIDX_W    (WIDX_W)
    ) u_dec (
        .addr (bus_addr),
        .kind (dec_kind),
        .word (dec_word)
    );

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic hit;
        assign hit = bus_wr_en && (dec_word == WIDX_W'(w));

        gpio_pin_word #(.WORD_W(WORD_W)) u_word (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_dir (hit && (dec_kind == RK_DIR)),
            .wr_set (hit && (dec_kind == RK_SET)),
            .wr_clr (hit && (dec_kind == RK_CLR)),
            .wdata  (bus_wdata),
            .out_q  (out_all[w*WORD_W +: WORD_W]),
            .dir_q  (dir_all[w*WORD_W +: WORD_W])
        );

        assign lvl_word[w] = lvl_all[w*WORD_W +: WORD_W];
        assign dir_word[w] = dir_all[w*WORD_W +: WORD_W];
    end

    always_comb begin
        st_d = st_q;
        if (bus_wr_en && dec_kind == RK_CFG) st_d.cfg = bus_wdata;
        st_d.rdata = '0;
        if (bus_rd_en) begin
            unique case (dec_kind)
                RK_CFG:   st_d.rdata = st_q.cfg;
                RK_LEVEL: st_d.rdata = lvl_word[dec_word];
                RK_DIR:   st_d.rdata = dir_word[dec_word];
                default:  st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;
    assign pad_out   = out_all[NUM_PINS-1:0];
    assign pad_oe    = dir_all[NUM_PINS-1:0];

    // R6: write-only runs read as zero
    p_wo_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && (dec_kind == RK_SET || dec_kind == RK_CLR)) |=> (bus_rdata == '0));

    // R8: unmapped reads return zero
    p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && dec_kind == RK_NONE) |=> (bus_rdata == '0));

    // R8: unmapped writes leave pads alone
    p_unmapped_nowr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_kind == RK_NONE || dec_kind == RK_LEVEL) |=> ($stable(pad_out) && $stable(pad_oe)));

    // R7: idle bus gives zero read data
    p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_en |=> (bus_rdata == '0));

endmodule

// File: tb/sim_gpio_bank.sv
module sim_gpio_bank;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [11:0]  bus_addr = '0;
    logic         bus_wr_en = 1'b0;
    logic [31:0]  bus_wdata = '0;
    logic         bus_rd_en = 1'b0;
    logic [31:0]  bus_rdata;
    logic [191:0] pad_in = '0;
    logic [191:0] pad_out;
    logic [191:0] pad_oe;

    logic [191:0] exp_out = '0;
    logic [191:0] exp_oe = '0;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    gpio_bank u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
        .bus_wdata(bus_wdata), .bus_rd_en(bus_rd_en), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic chk(input string req, input logic [191:0] act, input logic [191:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // all tasks enter and leave at a falling edge
    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd_en = 1'b1;
        @(negedge clk);
        bus_rd_en = 1'b0;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 pad_out", pad_out, '0);
        chk("R1 pad_oe", pad_oe, '0);
        bus_read(12'h01c, d);
        chk("R1 dir word0", {160'b0, d}, '0);
        bus_read(12'h030, d);
        chk("R1 dir word5", {160'b0, d}, '0);
    endtask

    task automatic t_set_clear();
        logic [31:0] d;
        bus_write(12'h034, 32'h8000_00F1);
        exp_out[31:0] = exp_out[31:0] | 32'h8000_00F1;
        chk("R2 set word0", pad_out, exp_out);
        bus_write(12'h038, 32'h0000_0001);
        exp_out[32] = 1'b1;
        chk("R10 pin32", pad_out, exp_out);
        bus_write(12'h048, 32'h8000_0000);
        exp_out[191] = 1'b1;
        chk("R10 pin191", pad_out, exp_out);
        bus_write(12'h034, 32'h0000_0000);
        chk("R2 zero bits keep", pad_out, exp_out);
        bus_write(12'h04c, 32'h0000_0011);
        exp_out[4] = 1'b0; exp_out[0] = 1'b0;
        chk("R3 clear word0", pad_out, exp_out);
        bus_write(12'h060, 32'h8000_0000);
        exp_out[191] = 1'b0;
        chk("R3 clear pin191", pad_out, exp_out);
        bus_write(12'h04c, 32'h0000_0002);
        chk("R3 clear of low bit", pad_out, exp_out);
        bus_read(12'h034, d);
        chk("R6 set reads zero", {160'b0, d}, '0);
        bus_read(12'h050, d);
        chk("R6 clear reads zero", {160'b0, d}, '0);
        chk("R2 direction untouched", pad_oe, exp_oe);
    endtask

    task automatic t_dir();
        logic [31:0] d;
        bus_write(12'h024, 32'hA5A5_0003);
        exp_oe[95:64] = 32'hA5A5_0003;
        chk("R4 pad_oe word2", pad_oe, exp_oe);
        bus_read(12'h024, d);
        chk("R4 dir readback", {160'b0, d}, {160'b0, 32'hA5A5_0003});
        bus_write(12'h030, 32'h8000_0000);
        exp_oe[191] = 1'b1;
        chk("R10 dir pin191", pad_oe, exp_oe);
        bus_write(12'h024, 32'h0000_0001);
        exp_oe[95:64] = 32'h0000_0001;
        chk("R4 dir rewrite", pad_oe, exp_oe);
        chk("R4 latch untouched", pad_out, exp_out);
    endtask

    task automatic t_level();
        logic [31:0] d;
        pad_in = '0;
        repeat (3) @(negedge clk);
        pad_in[63:32] = 32'hDEAD_BEEF;
        bus_read(12'h008, d);
        chk("R5 before edge+2", {160'b0, d}, '0);
        @(negedge clk);
        bus_read(12'h008, d);
        chk("R5 at edge+2", {160'b0, d}, {160'b0, 32'hDEAD_BEEF});
        pad_in[191] = 1'b1;
        repeat (2) @(negedge clk);
        bus_read(12'h018, d);
        chk("R10 level pin191", {160'b0, d}, {160'b0, 32'h8000_0000});
        bus_write(12'h008, 32'h0000_0000);
        bus_read(12'h008, d);
        chk("R5 level write ignored", {160'b0, d}, {160'b0, 32'hDEAD_BEEF});
        chk("R5 pads after level write", pad_out, exp_out);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        bus_write(12'h064, 32'hFFFF_FFFF);
        bus_write(12'h035, 32'hFFFF_FFFF);
        bus_write(12'h01e, 32'hFFFF_FFFF);
        bus_write(12'hFFC, 32'hFFFF_FFFF);
        chk("R8 pad_out after unmapped", pad_out, exp_out);
        chk("R8 pad_oe after unmapped", pad_oe, exp_oe);
        bus_read(12'h064, d);
        chk("R8 read 0x064", {160'b0, d}, '0);
        bus_read(12'h025, d);
        chk("R8 unaligned read", {160'b0, d}, '0);
        bus_read(12'h000, d);
        chk("R8 cfg untouched", {160'b0, d}, '0);
    endtask

    task automatic t_config();
        logic [31:0] d;
        bus_write(12'h000, 32'h1234_5678);
        chk("R9 pads unaffected", pad_out, exp_out);
        chk("R9 oe unaffected", pad_oe, exp_oe);
        bus_read(12'h000, d);
        chk("R9 cfg readback", {160'b0, d}, {160'b0, 32'h1234_5678});
        @(negedge clk);
        chk("R7 rdata zero when idle", {160'b0, bus_rdata}, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_set_clear();
        t_dir();
        t_level();
        t_unmapped();
        t_config();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule